// File: doc/BRIEF.md
# Packed Four-Lane 16-bit Multiplier Built From Byte Partials

This block multiplies a 64-bit packed operand, viewed as four independent 16-bit two's-complement lanes, by one shared 16-bit signed multiplicand. It does not use a full 16x16 array per lane. Each lane is cut into its two bytes, and each byte is multiplied by the multiplicand in an 8x16 partial product. The lower byte is taken as unsigned and the upper byte as signed. The upper partial product is shifted left by eight places and added to the lower one, which gives the exact 32-bit signed lane product.

The unit is a fixed three-stage pipeline. The first stage forms the partial products, the second merges them, and the third picks which 16-bit half of each lane product is returned. It accepts a new operation on every clock and never stalls. The half-select input travels down the pipe with its operands, so each result is shaped by the mode that was given with that result's own operation.

Top module: `pmul_top`

## Requirements
- R1: Lane i takes bits [16i+15:16i] of `in_a` and writes bits [16i+15:16i] of `out_result`. Each lane result comes only from that lane of `in_a` (signed 16-bit) times `in_b` (signed 16-bit). With `in_b` equal to zero, every lane product is zero.
- R2: With `in_half` = 0, each lane returns bits [15:0] of its 32-bit signed product.
- R3: With `in_half` = 1, each lane returns bits [31:16] of its 32-bit signed product. For nonzero operands, bit 15 of the lane result is the XOR of the operand signs.
- R4: An operation sampled with `in_valid` high at a rising edge appears with `out_valid` high after exactly the third rising edge that follows.
- R5: Operations may be presented on consecutive cycles. Every accepted operation yields exactly one result, and the results come out in issue order.
- R6: A synchronous active-high `rst` clears `out_valid` and `out_result` to zero and discards operations in flight.
- R7: In a cycle in which no result is delivered, `out_valid` is low and `out_result` keeps its previous value.
- R8: The half-select is captured together with its operands. Changing `in_half` on later cycles does not alter an operation already in the pipe.
- R9: Extreme operands give exact results. For example, -32768 x -32768 gives high half 0x4000 and low half 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_half | input | 1 | Result half select: 0 low, 1 high |
| in_a | input | 64 | Four packed signed 16-bit lanes |
| in_b | input | 16 | Shared signed 16-bit multiplicand |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Four packed 16-bit lane results |

## Verification
Errors inside the pipe show up at the ports exactly three cycles after the faulty operation is issued.
- A wrong signedness or shift on either byte partial corrupts the lanes whose bytes exercise it. The sweeps pair every corner lane value with every corner multiplicand so that the sign-bit and carry paths are driven, and the error appears on the first such result.
- A lost or duplicated valid bit breaks the fixed latency, or leaves a queued expectation unmatched.
- A mode bit that is not carried with its data gives the wrong half as soon as `in_half` changes between issue and completion.
- A result register that loads without valid breaks the hold check on the next idle cycle.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    parameter int LANES   = 4;
    parameter int LANE_W  = 16;
    parameter int MCAND_W = 16;

    localparam int SPLIT_W = LANE_W / 2;
    localparam int OPND_W  = LANES * LANE_W;
    localparam int PART_W  = SPLIT_W + 1 + MCAND_W;
    localparam int PROD_W  = LANE_W + MCAND_W;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    typedef logic signed [PART_W-1:0] part_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    typedef struct packed {
        logic                    valid;
        half_e                   half;
        logic [LANES-1:0][PART_W-1:0] hi_pp;
        logic [LANES-1:0][PART_W-1:0] lo_pp;
    } part_stage_t;

    typedef struct packed {
        logic                    valid;
        half_e                   half;
        logic [LANES-1:0][PROD_W-1:0] prod;
    } prod_stage_t;

    function automatic prod_t merge_partials(input logic [PART_W-1:0] hi,
                                             input logic [PART_W-1:0] lo);
        prod_t hi_ext;
        prod_t lo_ext;
        hi_ext = prod_t'($signed(hi));
        lo_ext = prod_t'($signed(lo));
        return (hi_ext <<< SPLIT_W) + lo_ext;
    endfunction

    function automatic logic [LANE_W-1:0] pick_half(input logic [PROD_W-1:0] p,
                                                    input half_e h);
        if (h == HALF_HI)
            return p[PROD_W-1 -: LANE_W];
        return p[LANE_W-1:0];
    endfunction

endpackage

// File: rtl/pmul_partials.sv
module pmul_partials
    import pmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  half_e             in_half,
    input  logic [OPND_W-1:0] a,
    input  logic [MCAND_W-1:0] b,
    output part_stage_t       s1
);

    logic [LANES-1:0][PART_W-1:0] hi_w;
    logic [LANES-1:0][PART_W-1:0] lo_w;
    part_t b_ext;

    assign b_ext = part_t'($signed(b));

    for (genvar l = 0; l < LANES; l++) begin : gen_lane
        logic [SPLIT_W-1:0] lo_byte;
        logic [SPLIT_W-1:0] hi_byte;
        part_t lo_op;
        part_t hi_op;
        part_t lo_pp;
        part_t hi_pp;

        assign lo_byte = a[l*LANE_W +: SPLIT_W];
        assign hi_byte = a[l*LANE_W + SPLIT_W +: SPLIT_W];
        // lower byte carries no sign, upper byte carries the lane sign
        assign lo_op   = part_t'({1'b0, lo_byte});
        assign hi_op   = part_t'($signed(hi_byte));
        assign lo_pp   = lo_op * b_ext;
        assign hi_pp   = hi_op * b_ext;
        assign lo_w[l] = lo_pp;
        assign hi_w[l] = hi_pp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            if (in_valid) begin
                s1.half  <= in_half;
                s1.hi_pp <= hi_w;
                s1.lo_pp <= lo_w;
            end
        end
    end

    // R1: zero multiplicand leaves both partials of every lane at zero
    assert_zero_mcand_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && b == '0) |=> (s1.hi_pp == '0 && s1.lo_pp == '0));

endmodule

// File: rtl/pmul_combine.sv
module pmul_combine
    import pmul_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  part_stage_t s1,
    output prod_stage_t s2
);

    logic [LANES-1:0][PROD_W-1:0] prod_w;

    for (genvar l = 0; l < LANES; l++) begin : gen_lane
        assign prod_w[l] = merge_partials(s1.hi_pp[l], s1.lo_pp[l]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.valid <= s1.valid;
            if (s1.valid) begin
                s2.half <= s1.half;
                s2.prod <= prod_w;
            end
        end
    end

    // R8: the half select moves one stage with its own operation
    assert_mode_travels_R8: assert property (@(posedge clk) disable iff (rst)
        s1.valid |=> (s2.valid && s2.half == $past(s1.half)));

endmodule

// File: rtl/pmul_select.sv
module pmul_select
    import pmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  prod_stage_t       s2,
    output logic              out_valid,
    output logic [OPND_W-1:0] out_result
);

    logic [OPND_W-1:0] result_w;

    for (genvar l = 0; l < LANES; l++) begin : gen_lane
        assign result_w[l*LANE_W +: LANE_W] = pick_half(s2.prod[l], s2.half);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= s2.valid;
            if (s2.valid)
                out_result <= result_w;
        end
    end

    // R7: nothing delivered means the result word does not move
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_result));

    // R5: every product leaving stage two becomes a delivered result
    assert_no_drop_R5: assert property (@(posedge clk) disable iff (rst)
        s2.valid |=> out_valid);

endmodule

// File: rtl/pmul_top.sv
module pmul_top
    import pmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_half,
    input  logic [OPND_W-1:0] in_a,
    input  logic [MCAND_W-1:0] in_b,
    output logic              out_valid,
    output logic [OPND_W-1:0] out_result
);

    part_stage_t s1;
    prod_stage_t s2;

    pmul_partials u_partials (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_half  (half_e'(in_half)),
        .a        (in_a),
        .b        (in_b),
        .s1       (s1)
    );

    pmul_combine u_combine (
        .clk (clk),
        .rst (rst),
        .s1  (s1),
        .s2  (s2)
    );

    pmul_select u_select (
        .clk        (clk),
        .rst        (rst),
        .s2         (s2),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    // cycles since reset, saturating, so history checks never reach into reset
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R4: output valid mirrors input valid three edges earlier
    assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    for (genvar l = 0; l < LANES; l++) begin : gen_sign_chk
        // R3: high half of a nonzero product carries the XOR of operand signs
        assert_sign_R3: assert property (@(posedge clk) disable iff (rst)
            (since_rst == 2'd3 && out_valid && $past(in_half, 3)
             && $past(in_a[l*LANE_W +: LANE_W], 3) != '0
             && $past(in_b, 3) != '0)
            |-> (out_result[l*LANE_W + LANE_W - 1] ==
                 ($past(in_a[l*LANE_W + LANE_W - 1], 3) ^ $past(in_b[MCAND_W-1], 3))));
    end

endmodule

// File: tb/sim_pmul_top.sv
module sim_pmul_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_half;
    logic [63:0] in_a;
    logic [15:0] in_b;
    logic        out_valid;
    logic [63:0] out_result;

    always #2 clk = ~clk;

    pmul_top u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_half    (in_half),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int wr     = 0;
    int rd     = 0;
    logic [63:0] last_res = '0;
    logic [63:0] exp_val [0:4095];
    int          exp_cyc [0:4095];
    string       exp_req [0:4095];
    logic [31:0] lfsr = 32'h1BADF00D;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] model(input logic [63:0] a, input logic [15:0] b,
                                          input logic h);
        logic [63:0] r;
        longint p;
        for (int l = 0; l < 4; l++) begin
            p = longint'($signed(a[16*l +: 16])) * longint'($signed(b));
            r[16*l +: 16] = h ? p[31:16] : p[15:0];
        end
        return r;
    endfunction

    function automatic logic [15:0] corner(input int i);
        case (i % 16)
            0:  return 16'h8000;
            1:  return 16'h8001;
            2:  return 16'hFF00;
            3:  return 16'hFF01;
            4:  return 16'hFF7F;
            5:  return 16'hFF80;
            6:  return 16'hFFFF;
            7:  return 16'h0000;
            8:  return 16'h0001;
            9:  return 16'h007F;
            10: return 16'h0080;
            11: return 16'h00FF;
            12: return 16'h0100;
            13: return 16'h7FFF;
            14: return 16'h1234;
            default: return 16'hA5C3;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic check_out();
        if (rst) return;
        if (out_valid) begin
            if (rd == wr) begin
                chk(1'b0, "R5", out_result, 64'h0);
            end else begin
                chk(out_result == exp_val[rd % 4096], exp_req[rd % 4096],
                    out_result, exp_val[rd % 4096]);
                chk(cyc - exp_cyc[rd % 4096] == 3, "R4",
                    64'(cyc - exp_cyc[rd % 4096]), 64'd3);
                rd++;
            end
            last_res = out_result;
        end else begin
            chk(out_result == last_res, "R7", out_result, last_res);
        end
    endtask

    task automatic step(input logic v, input logic [63:0] a, input logic [15:0] b,
                        input logic h, input string req);
        @(negedge clk);
        check_out();
        in_valid = v;
        in_a     = a;
        in_b     = b;
        in_half  = h;
        if (v) begin
            exp_val[wr % 4096] = model(a, b, h);
            exp_cyc[wr % 4096] = cyc;
            exp_req[wr % 4096] = req;
            wr++;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 5; i++) step(1'b0, 64'h0, 16'h0, 1'b0, "R7");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_half = 1'b0; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6: state right after reset
        chk(out_valid == 1'b0, "R6", {63'h0, out_valid}, 64'h0);
        chk(out_result == '0, "R6", out_result, 64'h0);

        // R1 R2 R3: corner multiplicands against corner lane mixes, back to back
        for (int bi = 0; bi < 16; bi++) begin
            for (int ai = 0; ai < 64; ai++) begin
                logic [63:0] a;
                for (int l = 0; l < 4; l++) a[16*l +: 16] = corner(ai * (l + 1) + l * 3 + bi);
                step(1'b1, a, corner(bi), ai[0], ai[0] ? "R3" : (bi == 7 ? "R1" : "R2"));
            end
        end
        drain();

        // R9: extreme operands in both halves
        step(1'b1, {4{16'h8000}}, 16'h8000, 1'b1, "R9");
        step(1'b1, {4{16'h8000}}, 16'h8000, 1'b0, "R9");
        step(1'b1, {16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001}, 16'h7FFF, 1'b1, "R9");
        step(1'b1, {16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001}, 16'h8000, 1'b0, "R9");
        drain();

        // R8: mode flips while an operation is in flight
        step(1'b1, 64'h1357_9BDF_F00D_8421, 16'hC001, 1'b1, "R8");
        step(1'b0, 64'h0, 16'h0, 1'b0, "R8");
        step(1'b0, 64'h0, 16'h0, 1'b1, "R8");
        step(1'b1, 64'h1357_9BDF_F00D_8421, 16'hC001, 1'b0, "R8");
        step(1'b0, 64'h0, 16'h0, 1'b1, "R8");
        drain();

        // R4: lone operation latency
        step(1'b1, 64'h0102_0304_0506_0708, 16'h0203, 1'b0, "R4");
        drain();

        // R5 R7: random stream with gaps and random modes
        for (int i = 0; i < 1500; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            step(lfsr[0] | lfsr[1], {lfsr, lfsr[15:0], lfsr[31:16]} ^ 64'(i * 40503),
                 lfsr[27:12], lfsr[3], "R5");
        end
        drain();
        chk(rd == wr, "R5", 64'(rd), 64'(wr));

        // R6: reset while operations are in flight
        step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 16'h7FFF, 1'b1, "R6");
        step(1'b1, 64'h1111_2222_3333_4444, 16'h5555, 1'b0, "R6");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd = wr;
        last_res = '0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R6", {63'h0, out_valid}, 64'h0);
            chk(out_result == '0, "R6", out_result, 64'h0);
        end

        summary();
        $finish;
    end

endmodule